// File: doc/BRIEF.md
# Wait-State APB Register Completer

This block is an APB completer that fronts a flat bank of 32-bit registers and deliberately stretches every transfer. A requester starts a transfer with a one-cycle setup phase. The completer then keeps PREADY low for a chosen number of access cycles before it finishes. Requesters, drivers and bus monitors placed against it therefore see real wait states, not the zero-latency behaviour that hides early-sampling bugs.

The wait count for each transfer is fixed on the setup cycle and comes from one of three sources: an internal 16-bit LFSR (one to three waits), a zero-wait setting, or a count forced from a configuration input. While the completer is stalling a read, it drives the bitwise complement of the value it will finally return. A requester that samples PRDATA before PREADY therefore always gets a wrong word. Addresses that fall outside the register bank complete with an error response.

The handshake is the APB one. PREADY is the completer's back-pressure. The requester must hold PSEL, PENABLE, PADDR, PWRITE and PWDATA stable during the access phase until the cycle where PREADY is high, and that cycle is the only one in which the transfer takes effect. The mode inputs are plain control pins. They are sampled on the setup cycle.

Top module: `apb_ws_slave`

## Requirements
- R1: After reset, pready, pslverr and prdata are low and every register reads back as zero.
- R2: Whenever psel is low, pready, pslverr and prdata are all low. In the setup cycle (psel high, penable low), pready is low.
- R3: With wait_mode = 1 (zero-wait), pready is high in the first access cycle.
- R4: With wait_mode = 2 or 3 (forced), pready stays low for exactly forced_waits access cycles and rises in access cycle forced_waits+1.
- R5: With wait_mode = 0 (random), each transfer gets between one and three wait cycles inclusive. Over many transfers, more than one distinct count occurs.
- R6: In a read access cycle with pready low, prdata equals the bitwise complement of the word the transfer returns on completion. In write transfers, prdata is zero.
- R7: A read returns the register selected by paddr[ADDR_W-1:2] in the cycle where pready is high. paddr[1:0] is ignored.
- R8: A write to a mapped register is stored on the completion cycle and is returned by later reads.
- R9: A register index of NUM_REGS or above completes with pslverr high and returns zero read data. A write to such an index changes no register. pslverr is never high without pready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; word index in bits ADDR_W-1:2 |
| pwdata | input | DATA_W | Write data |
| wait_mode | input | 2 | 0 random, 1 zero-wait, 2 or 3 forced |
| forced_waits | input | 2 | Wait count used in forced mode |
| pready | output | 1 | Transfer completes in this access cycle |
| prdata | output | DATA_W | Read data, valid only with pready |
| pslverr | output | 1 | Error response for unmapped index |

## Verification
The bench builds the completer with ADDR_W = 8 and NUM_REGS = 6. Because the bank size is not a power of two, indices 6 and 7 are unmapped even though they lie just past the last register, and indices up to 63 are also reachable. This exercises the range decode at its exact edge as well as far beyond it. The forced mode gives exact wait counts from zero to three, so the complemented stall data and the completion cycle can be checked at every length. The random mode is checked for its bounds and for variety.

// File: rtl/apb_ws_pkg.sv
package apb_ws_pkg;
  typedef enum logic [1:0] {
    WS_RANDOM = 2'd0,
    WS_ZERO   = 2'd1,
    WS_FIXED  = 2'd2,
    WS_FIXED2 = 2'd3
  } ws_mode_e;

  localparam int WAIT_W = 2;

  function automatic logic [WAIT_W-1:0] rnd_to_wait(input logic [WAIT_W-1:0] v);
    return (v == '0) ? WAIT_W'(3) : v;
  endfunction
endpackage

// File: rtl/apb_ws_lfsr.sv
module apb_ws_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else if (step) state <= {1'b0, state[W-1:1]} ^ (state[0] ? TAPS : '0);
  end
endmodule

// File: rtl/apb_ws_wait_ctl.sv
module apb_ws_wait_ctl #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup,
  input  logic             access,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (setup)              cnt <= load_val;
    else if (access && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/apb_ws_regbank.sv
module apb_ws_regbank #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              hit
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  assign hit = ({{(32-IDX_W){1'b0}}, idx} < 32'(NUM_REGS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en && hit) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/apb_ws_slave.sv
module apb_ws_slave
  import apb_ws_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter int          NUM_REGS  = 8,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [1:0]        wait_mode,
  input  logic [1:0]        forced_waits,
  output logic              pready,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr
);
  localparam int IDX_W = ADDR_W - 2;

  logic              setup_ph, access_ph, cnt_done, hit;
  logic [LFSR_W-1:0] lfsr_state;
  logic [WAIT_W-1:0] wait_sel;
  logic [DATA_W-1:0] rd_val;
  ws_mode_e          mode;
  logic              unused_bits;

  assign setup_ph  = psel & ~penable;
  assign access_ph = psel & penable;
  assign mode      = ws_mode_e'(wait_mode);

  apb_ws_lfsr #(.W(LFSR_W), .TAPS(LFSR_W'(16'hB400)), .SEED(LFSR_W'(LFSR_SEED))) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(setup_ph), .state(lfsr_state)
  );

  always_comb begin
    unique case (mode)
      WS_RANDOM: wait_sel = rnd_to_wait(lfsr_state[WAIT_W-1:0]);
      WS_ZERO:   wait_sel = '0;
      default:   wait_sel = forced_waits;
    endcase
  end

  apb_ws_wait_ctl #(.CNT_W(WAIT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .setup(setup_ph), .access(access_ph),
    .load_val(wait_sel), .done(cnt_done)
  );

  apb_ws_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(pready & pwrite), .idx(paddr[ADDR_W-1:2]),
    .wdata(pwdata), .rdata(rd_val), .hit(hit)
  );

  assign pready  = access_ph & cnt_done;
  assign pslverr = pready & ~hit;
  assign prdata  = (access_ph && !pwrite) ? (pready ? rd_val : ~rd_val) : '0;

  assign unused_bits = ^{paddr[1:0], lfsr_state[LFSR_W-1:WAIT_W]};
endmodule

// File: rtl/apb_ws_checker.sv
module apb_ws_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       psel,
  input logic       penable,
  input logic [1:0] wait_mode,
  input logic [1:0] forced_waits,
  input logic       pready,
  input logic       pslverr
);
  logic [2:0] wait_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_run <= '0;
    else if (psel && penable && !pready) wait_run <= wait_run + 3'd1;
    else wait_run <= '0;
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> (!pready && !pslverr));

  assert_setup_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |-> !pready);

  assert_err_with_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> pready);

  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && wait_mode == 2'd1) |=> (!(psel && penable) || pready));

  assert_random_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable && wait_mode == 2'd0) |=> (!(psel && penable) || !pready));

  assert_random_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready && wait_mode == 2'd0) |-> (wait_run < 3'd3));

  assert_forced_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready && wait_mode[1]) |-> (wait_run < {1'b0, forced_waits}));
endmodule

bind apb_ws_slave apb_ws_checker u_apb_ws_checker (.*);

// File: tb/tb_apb_ws_slave.sv
`timescale 1ns/1ps
module tb_apb_ws_slave;
  localparam int AW = 8;
  localparam int NR = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [1:0] wait_mode = 2'd1, forced_waits = 2'd0;
  logic pready, pslverr;
  logic [31:0] prdata;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [31:0] model [NR];
  int seen [4];

  always #2.5 clk = ~clk;

  apb_ws_slave #(.ADDR_W(AW), .NUM_REGS(NR)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .wait_mode(wait_mode), .forced_waits(forced_waits),
    .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(string req);
    chk(pready == 1'b0, req, "idle pready", 32'(pready), 0);
    chk(pslverr == 1'b0, req, "idle pslverr", 32'(pslverr), 0);
    chk(prdata == 32'h0, req, "idle prdata", prdata, 0);
  endtask

  // exp_w < 0 means random mode: 1..3 waits expected
  task automatic xfer(bit wr, logic [AW-1:0] addr, logic [31:0] wd, int exp_w, string wreq);
    int idx = int'(addr >> 2);
    bit hit = idx < NR;
    logic [31:0] exp_rd = hit ? model[idx] : 32'h0;
    int waits = 0;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = addr; pwdata = wd;
    #1 chk(pready == 1'b0, "R2", "setup pready", 32'(pready), 0);
    @(negedge clk);
    penable = 1;
    forever begin
      #1;
      if (pready) break;
      waits++;
      if (!wr) chk(prdata === ~exp_rd, "R6", "stall prdata", prdata, ~exp_rd);
      else     chk(prdata == 32'h0, "R6", "write prdata", prdata, 0);
      chk(pslverr == 1'b0, "R9", "stall pslverr", 32'(pslverr), 0);
      if (waits > 4) break;
      @(negedge clk);
    end
    if (exp_w >= 0) chk(waits == exp_w, wreq, "wait count", 32'(waits), 32'(exp_w));
    else begin
      chk(waits >= 1 && waits <= 3, "R5", "random wait count", 32'(waits), 2);
      if (waits <= 3) seen[waits]++;
    end
    chk(pslverr == !hit, "R9", "completion pslverr", 32'(pslverr), 32'(!hit));
    if (!wr) chk(prdata === exp_rd, hit ? "R7" : "R9", "read data", prdata, exp_rd);
    if (wr && hit) model[idx] = wd;
    @(negedge clk);
    psel = 0; penable = 0;
    #1 check_idle("R2");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = 32'h0;
    for (int i = 0; i < 4; i++) seen[i] = 0;
    #1 check_idle("R1");
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1 check_idle("R1");

    // R1: reset contents, zero-wait reads (R3)
    wait_mode = 2'd1;
    for (int i = 0; i < NR; i++) xfer(0, AW'(i * 4), 0, 0, "R3");

    // R8: writes then readback, zero-wait
    for (int i = 0; i < NR; i++) xfer(1, AW'(i * 4), 32'hA5000000 + 32'(i * 32'h1111), 0, "R3");
    for (int i = 0; i < NR; i++) xfer(0, AW'(i * 4), 0, 0, "R3");

    // R4 / R6: forced counts 0..3 on reads and writes
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); wait_mode = (w % 2 == 0) ? 2'd2 : 2'd3; forced_waits = 2'(w);
      xfer(1, AW'(w * 4), 32'hC0DE0000 + 32'(w), w, "R4");
      xfer(0, AW'(w * 4), 0, w, "R4");
      xfer(0, AW'(w * 4 + 4), 0, w, "R4");
    end

    // R7: low address bits ignored
    @(negedge clk); wait_mode = 2'd2; forced_waits = 2'd2;
    xfer(0, 8'h09, 0, 2, "R4");
    xfer(1, 8'h13, 32'h600DF00D, 2, "R4");
    xfer(0, 8'h10, 0, 2, "R4");

    // R9: unmapped indices 6, 7 and 63; registers untouched
    xfer(1, 8'h18, 32'hDEADBEEF, 2, "R4");
    xfer(0, 8'h18, 0, 2, "R4");
    xfer(1, 8'h1C, 32'h12345678, 1 + 1, "R4");
    xfer(0, 8'hFC, 0, 2, "R4");
    for (int i = 0; i < NR; i++) xfer(0, AW'(i * 4), 0, 2, "R4");

    // R5: random waits, mixed traffic
    @(negedge clk); wait_mode = 2'd0;
    for (int k = 0; k < 40; k++) begin
      int a = (k * 7) % 8;
      xfer(k % 3 == 0, AW'(a * 4), 32'h5A5A0000 ^ 32'(k), -1, "R5");
    end
    begin
      int kinds = 0;
      for (int i = 1; i < 4; i++) if (seen[i] > 0) kinds++;
      chk(kinds >= 2, "R5", "distinct random counts", 32'(kinds), 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule